// File: doc/BRIEF.md
# Per-Channel Overload Shutdown Timer

This block watches a bank of low-side output channels and switches off any channel that stays in current limit for too long. Each channel has a flag from an analog comparator. The flag is high while that channel's driver is limiting current. While the channel is switched on and its flag is high, a private counter counts ticks from a divided internal oscillator. If the flag stays high for a programmable number of ticks, the channel's bit in the output latch is forced to the off state. The counter is then cleared, so no fault is kept. A later write of 0 to that bit turns the channel back on and starts supervision again. If the short is still there, the same sequence repeats.

The output latch is loaded from a word that the serial shift logic delivers when a transfer completes. A latch bit of 1 means off and a bit of 0 means on. The write interface is a valid/ready pair. `wr_ready` is always high, so the block never applies back-pressure: every cycle with `wr_valid` high transfers `wr_data`. A test input selects a much shorter terminal count. While the test input is high, the block also brings out the oscillator tick divided by two, to be routed to the serial output pin.

Top module: `ovl_shutdown_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `drv_off` is all ones (every channel off), every channel counter is zero and `test_clk_out` is 0. This holds for a reset applied in the middle of operation.
- R2: In a cycle with `wr_valid` high, `drv_off` takes `wr_data` on the next clock edge (bit i = 1 means channel i off, 0 means on). `wr_ready` is always 1. With no write and no trip, `drv_off` holds its value.
- R3: Take a channel that is on with `ilim` high. On the `TRIP_TICKS`-th consecutive `osc_tick` pulse (37 by default) its `drv_off` bit becomes 1 at the following clock edge. After `TRIP_TICKS`-1 pulses the bit is still 0.
- R4: If `ilim` of a channel goes low for at least one clock before the limit is reached, its count returns to zero. A later limit episode again needs a full `TRIP_TICKS` pulses.
- R5: After a trip the count is zero. A write of 0 turns the channel back on, and a limit that is still present trips it again only after another full `TRIP_TICKS` pulses.
- R6: Each channel is timed on its own. A trip sets only that channel's `drv_off` bit, and other channels' bits and counts are unaffected.
- R7: While `test_mode` is high, the terminal count is `TEST_TICKS` pulses (4 by default) instead of `TRIP_TICKS`.
- R8: While `test_mode` is high, `test_clk_out` toggles at the clock edge of every `osc_tick` pulse. While `test_mode` is low, `test_clk_out` is 0 one clock later.
- R9: If a channel trips in the same cycle as a write, that channel's bit becomes 1 whatever was written, and every other bit takes the written value.
- R10: While a channel's `drv_off` bit is 1, its counter stays at zero even with `ilim` high. After a write of 0, a full `TRIP_TICKS` pulses are needed to trip it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, power-on and external reset already combined |
| osc_tick | input | 1 | One-clock pulse from the divided internal oscillator |
| test_mode | input | 1 | Selects the shortened terminal count and enables the divided-by-two tick output |
| ilim | input | NCH | Per-channel current-limit flag, synchronous to clk |
| wr_valid | input | 1 | A latch word is offered on wr_data |
| wr_ready | output | 1 | Always 1: the latch accepts a word in every cycle |
| wr_data | input | NCH | New latch word, 1 = off, 0 = on |
| drv_off | output | NCH | Output latch driving the channel drivers, 1 = off |
| test_clk_out | output | 1 | Oscillator tick divided by two while test_mode is high, else 0 |

## Verification
The assertions assume that `ilim`, `osc_tick`, `test_mode` and the write pair are already synchronous to `clk` and are stable around each rising edge. They also assume that an `osc_tick` pulse lasts exactly one clock, so that one pulse advances a counter by one. The stimulus changes every input only on the falling clock edge and produces ticks as single-cycle pulses separated by idle cycles. Trip, write and tick collisions are created on purpose on that same falling-edge schedule.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // Timebase seen by every channel timer
  typedef struct packed {
    logic tick;        // one-clock oscillator pulse
    logic short_mode;  // shortened terminal count selected
  } tbase_t;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ovl_tick_div.sv
module ovl_tick_div
  import ovl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   osc_tick,
  input  logic   test_mode,
  output tbase_t tb,
  output logic   div2_q
);
  assign tb.tick       = osc_tick;
  assign tb.short_mode = test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div2_q <= 1'b0;
    else if (!test_mode) div2_q <= 1'b0;
    else if (osc_tick)   div2_q <= ~div2_q;
  end

  // R8: each tick in test mode flips the divided output
  assert_div_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && osc_tick) |=> (div2_q != $past(div2_q)));

  // R8: divided output parked low outside test mode
  assert_div_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> !div2_q);
endmodule

// File: rtl/ovl_chan_timer.sv
module ovl_chan_timer
  import ovl_pkg::*;
#(
  parameter int unsigned TRIP_TICKS = 37,
  parameter int unsigned TEST_TICKS = 4,
  localparam int unsigned CW = cnt_width(TRIP_TICKS)
)(
  input  logic   clk,
  input  logic   rst_n,
  input  tbase_t tb,
  input  logic   ilim,
  input  logic   chan_off,
  output logic   trip_req
);
  localparam logic [CW-1:0] TRIP_M1 = CW'(TRIP_TICKS - 1);
  localparam logic [CW-1:0] TEST_M1 = CW'(TEST_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;
  logic          armed;

  assign last_val = tb.short_mode ? TEST_M1 : TRIP_M1;
  assign armed    = ilim && !chan_off;
  // >= so a switch to the short count mid-episode trips on the next tick
  assign trip_req = armed && tb.tick && (cnt_q >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!armed)  cnt_q <= '0;
    else if (tb.tick) cnt_q <= trip_req ? '0 : cnt_q + CW'(1);
  end

  // R3: the count never passes the long terminal value
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TRIP_M1);

  // R4: limit gone means the count restarts
  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ilim |=> (cnt_q == '0));

  // R10: a switched-off channel accumulates nothing
  assert_off_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_off |=> (cnt_q == '0));

  // R5: a trip leaves no memory in the counter
  assert_trip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_req |=> (cnt_q == '0));
endmodule

// File: rtl/ovl_out_latch.sv
module ovl_out_latch #(
  parameter int unsigned NCH = 8
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_fire,
  input  logic [NCH-1:0] wr_data,
  input  logic [NCH-1:0] trip_req,
  output logic [NCH-1:0] drv_off
);
  logic [NCH-1:0] base_nxt;

  assign base_nxt = wr_fire ? wr_data : drv_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_off <= '1;
    else        drv_off <= base_nxt | trip_req;
  end

  // R9: a trip request always lands as off, even against a write
  assert_trip_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_req != '0) |=> ((drv_off & $past(trip_req)) == $past(trip_req)));

  // R2: quiet cycles leave the latch alone
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && trip_req == '0) |=> $stable(drv_off));

  // R6: bits neither written nor tripped keep their value
  assert_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ((drv_off & ~$past(drv_off) & ~$past(trip_req)) == '0));
endmodule

// File: rtl/ovl_shutdown_guard.sv
module ovl_shutdown_guard
  import ovl_pkg::*;
#(
  parameter int unsigned NCH        = 8,
  parameter int unsigned TRIP_TICKS = 37,
  parameter int unsigned TEST_TICKS = 4
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_tick,
  input  logic           test_mode,
  input  logic [NCH-1:0] ilim,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] drv_off,
  output logic           test_clk_out
);
  tbase_t         tb;
  logic [NCH-1:0] trip_req;
  logic           wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  ovl_tick_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .test_mode (test_mode),
    .tb        (tb),
    .div2_q    (test_clk_out)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    ovl_chan_timer #(
      .TRIP_TICKS (TRIP_TICKS),
      .TEST_TICKS (TEST_TICKS)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb       (tb),
      .ilim     (ilim[gi]),
      .chan_off (drv_off[gi]),
      .trip_req (trip_req[gi])
    );
  end

  ovl_out_latch #(.NCH(NCH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wr_data  (wr_data),
    .trip_req (trip_req),
    .drv_off  (drv_off)
  );

  // R3: a channel only goes off through a write or its own trip
  assert_off_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ((drv_off & ~$past(drv_off) & ~$past(ilim)) == '0));
endmodule

// File: tb/ovl_shutdown_guard_tb_top.sv
module ovl_shutdown_guard_tb_top;
  localparam int NCH  = 8;
  localparam int TRIP = 37;
  localparam int TST  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           osc_tick = 1'b0;
  logic           test_mode = 1'b0;
  logic [NCH-1:0] ilim = '0;
  logic           wr_valid = 1'b0;
  logic [NCH-1:0] wr_data = '0;
  logic           wr_ready;
  logic [NCH-1:0] drv_off;
  logic           test_clk_out;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string phase = "R1";

  // behavioural reference state
  int             m_cnt [NCH];
  logic [NCH-1:0] m_off = '1;
  logic           m_div = 1'b0;

  always #10 clk = ~clk;

  ovl_shutdown_guard #(.NCH(NCH), .TRIP_TICKS(TRIP), .TEST_TICKS(TST)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .test_mode(test_mode),
    .ilim(ilim), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .drv_off(drv_off), .test_clk_out(test_clk_out)
  );

  // reference model: advance on every rising edge
  always @(posedge clk) begin
    logic [NCH-1:0] trips;
    logic [NCH-1:0] nxt;
    int lim;
    if (!rst_n) begin
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_off = '1;
      m_div = 1'b0;
    end else begin
      lim   = test_mode ? TST : TRIP;
      trips = '0;
      for (int k = 0; k < NCH; k++) begin
        if (!ilim[k] || m_off[k]) m_cnt[k] = 0;
        else if (osc_tick) begin
          if (m_cnt[k] + 1 >= lim) begin
            m_cnt[k] = 0;
            trips[k] = 1'b1;
          end else m_cnt[k] = m_cnt[k] + 1;
        end
      end
      nxt   = wr_valid ? wr_data : m_off;
      m_off = nxt | trips;
      if (!test_mode)    m_div = 1'b0;
      else if (osc_tick) m_div = ~m_div;
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    n_chk++;
    if (drv_off !== m_off || test_clk_out !== m_div || wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL [%s] model compare: drv_off=%h div=%b rdy=%b exp drv_off=%h div=%b rdy=1",
               phase, drv_off, test_clk_out, wr_ready, m_off, m_div);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL [watchdog] act=%0d cycles exp<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL [%s] act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [NCH-1:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic tick_and_write(logic [NCH-1:0] d);
    @(negedge clk); osc_tick = 1'b1; wr_valid = 1'b1; wr_data = d;
    @(negedge clk); osc_tick = 1'b0; wr_valid = 1'b0;
  endtask

  initial begin
    idle(4);
    chk("R1 off during reset", drv_off, '1);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    chk("R1 off after reset", drv_off, '1);
    chk("R1 div after reset", {7'd0, test_clk_out}, 8'h00);

    phase = "R2";
    write(8'h00);
    chk("R2 write all on", drv_off, 8'h00);
    write(8'h5A);
    chk("R2 write pattern", drv_off, 8'h5A);
    idle(3);
    chk("R2 hold", drv_off, 8'h5A);
    write(8'h00);

    phase = "R3";
    ilim = 8'h01;
    ticks(TRIP - 1);
    chk("R3 one short of limit", drv_off, 8'h00);
    ticks(1);
    chk("R3 R6 trip ch0 only", drv_off, 8'h01);

    phase = "R5";
    ticks(40);
    chk("R5 stays off without rewrite", drv_off, 8'h01);
    write(8'h00);
    ticks(TRIP - 1);
    chk("R5 retry full window", drv_off, 8'h00);
    ticks(1);
    chk("R5 retrip", drv_off, 8'h01);
    ilim = '0;

    phase = "R4";
    write(8'h00);
    ilim = 8'h02;
    ticks(20);
    ilim = 8'h00;
    idle(1);
    ilim = 8'h02;
    ticks(TRIP - 1);
    chk("R4 count restarted", drv_off, 8'h00);
    ticks(1);
    chk("R4 trip after full window", drv_off, 8'h02);
    ilim = '0;

    phase = "R10";
    write(8'h08);
    ilim = 8'h08;
    ticks(50);
    chk("R10 off channel holds", drv_off, 8'h08);
    write(8'h00);
    ticks(TRIP - 1);
    chk("R10 no accumulated count", drv_off, 8'h00);
    ticks(1);
    chk("R10 trip after enable", drv_off, 8'h08);
    ilim = '0;

    phase = "R8";
    write(8'h00);
    @(negedge clk); test_mode = 1'b1;
    ticks(1);
    chk("R8 div high", {7'd0, test_clk_out}, 8'h01);
    ticks(1);
    chk("R8 div low", {7'd0, test_clk_out}, 8'h00);

    phase = "R7";
    ilim = 8'h10;
    ticks(TST - 1);
    chk("R7 short count not reached", drv_off, 8'h00);
    ticks(1);
    chk("R7 short count trip", drv_off, 8'h10);
    ilim = '0;
    @(negedge clk); test_mode = 1'b0;
    idle(1);
    chk("R8 div parked", {7'd0, test_clk_out}, 8'h00);

    phase = "R9";
    write(8'h00);
    ilim = 8'h04;
    ticks(TRIP - 1);
    tick_and_write(8'h00);
    chk("R9 trip beats write 0", drv_off, 8'h04);
    write(8'h00);
    ticks(TRIP - 1);
    tick_and_write(8'hA0);
    chk("R9 others take written value", drv_off, 8'hA4);
    ilim = '0;

    phase = "R6";
    write(8'h00);
    ilim = 8'h60;
    ticks(10);
    ilim = 8'h20;
    ticks(TRIP - 10);
    chk("R6 ch5 trips alone", drv_off, 8'h20);
    ilim = 8'h40;
    ticks(9);
    chk("R6 ch6 count unaffected", drv_off, 8'h20);
    ilim = '0;

    phase = "R1";
    ilim = 8'h01;
    write(8'h00);
    ticks(5);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    chk("R1 mid-run reset", drv_off, '1);
    @(negedge clk); rst_n = 1'b1;
    ilim = '0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule